// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up noisy digital inputs on a multi-port I/O bank. Each port carries a byte of raw input levels. Every bit is brought into the system clock domain and then held back until its new level has stayed unchanged for a programmable number of debounce ticks. Only then does the filtered output take the new level. Any bounce during the interval throws the partial count away, so a pulse shorter than the interval never reaches the output.

The debounce ticks come from one of two sources, picked by a single select bit. One is a one-cycle strobe from an internal reference divider, nominally 8 MHz. The other is the rising edge of an external clock pin, which the block synchronises itself. Ports are arranged in groups that share a 2-bit duration code. With the default parameters the four codes give 32, 512, 8192 and 65536 ticks, which is 4 µs, 64 µs, 1 ms and 8 ms at 8 MHz. Each port has its own enable bit. A disabled port drives its raw inputs straight to the output.

Top module: `debounce_filter`

## Requirements
- R1: While rst_ni is low, every bit of an enabled port reads 0 on data_o.
- R2: Duration code value c (0..3) on a group's 2-bit field selects 2^LOG2_Tc ticks (defaults 32, 512, 8192, 65536). A code change takes effect at once, and a count already at or beyond the new length accepts on the next tick.
- R3: Each raw bit passes through SYNC_STAGES flops plus one comparison stage. With a tick on every cycle and SYNC_STAGES=2, a level change on raw_i appears on data_o exactly N+3 rising clock edges after it is applied, where N is the selected tick count.
- R4: Any change in the synchronised level of a bit before acceptance restarts its count from zero. A pulse shorter than N ticks never reaches data_o.
- R5: clk_sel_i=1 takes ticks from the int_tick_i strobe. clk_sel_i=0 takes one tick per rising edge of ext_clk_i, after a two-flop synchroniser. Without ticks, an enabled port's output does not change.
- R6: When filt_en_i[p] is 0, data_o bits of port p equal raw_i bits of port p combinationally.
- R7: Port p uses the code at dur_code_i[2*g+1:2*g], where g = p / GROUP_PORTS.
- R8: Each bit is filtered on its own counter. A change on one bit neither delays nor triggers any other bit.
- R9: While a port is disabled, its filter state tracks the synchronised input. Enabling the port after the input has been stable for SYNC_STAGES+1 cycles causes no change on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | NUM_PORTS*PORT_W | Raw input levels, port p at bits p*PORT_W upward |
| int_tick_i | input | 1 | One-cycle strobe from the internal reference divider |
| ext_clk_i | input | 1 | External debounce clock, asynchronous |
| clk_sel_i | input | 1 | 1 selects int_tick_i, 0 selects ext_clk_i rising edges |
| dur_code_i | input | 2*NUM_GROUPS | Duration code per port group |
| filt_en_i | input | NUM_PORTS | Per-port filter enable, 0 bypasses |
| data_o | output | NUM_PORTS*PORT_W | Filtered levels |

## Verification
The bench builds four ports of eight bits in two groups of two. It shrinks the four duration exponents to 2, 3, 4 and 5, so the codes give 4, 8, 16 and 32 ticks. This puts every code, the exact acceptance latency, restart after a glitch and group-to-code mapping within a few dozen cycles. Tens of thousands of random cycles also switch codes, enables and the tick source while counts are in flight.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic [1:0] {
    DUR_SHORT = 2'd0,
    DUR_MID   = 2'd1,
    DUR_LONG  = 2'd2,
    DUR_MAX   = 2'd3
  } dur_code_e;

  function automatic int unsigned dbf_max4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dbf_tick_sel.sv
module dbf_tick_sel #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic int_tick_i,
  input  logic ext_clk_i,
  input  logic clk_sel_i,
  output logic tick_o
);
  // SYNC_STAGES synchroniser flops plus one edge-history flop
  logic [SYNC_STAGES:0] ext_q;
  logic                 ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= '0;
    else         ext_q <= {ext_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = ext_q[SYNC_STAGES-1] & ~ext_q[SYNC_STAGES];
  assign tick_o   = clk_sel_i ? int_tick_i : ext_rise;

endmodule

// File: rtl/dbf_dur_decode.sv
module dbf_dur_decode import dbf_pkg::*; #(
  parameter int unsigned LOG2_T0 = 5,
  parameter int unsigned LOG2_T1 = 9,
  parameter int unsigned LOG2_T2 = 13,
  parameter int unsigned LOG2_T3 = 16,
  parameter int unsigned CNT_W   = 16
) (
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] limit_o
);
  // limit is the terminal count, one less than the tick count
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'((64'd1 << LOG2_T0) - 64'd1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'((64'd1 << LOG2_T1) - 64'd1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'((64'd1 << LOG2_T2) - 64'd1);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'((64'd1 << LOG2_T3) - 64'd1);

  always_comb begin
    unique case (dur_code_e'(code_i))
      DUR_SHORT: limit_o = LIM0;
      DUR_MID:   limit_o = LIM1;
      DUR_LONG:  limit_o = LIM2;
      default:   limit_o = LIM3;
    endcase
  end

endmodule

// File: rtl/dbf_bit_cell.sv
module dbf_bit_cell #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic                   prev_q;
  logic                   out_q;
  logic [CNT_W-1:0]       cnt_q;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      prev_q <= smp;
      if (!en_i) begin
        out_q <= smp;                 // track while bypassed
        cnt_q <= '0;
      end else if ((smp != prev_q) || (smp == out_q)) begin
        cnt_q <= '0;                  // bounce or nothing pending
      end else if (tick_i) begin
        if (cnt_q >= limit_i) begin
          out_q <= smp;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign filt_o = out_q;

endmodule

// File: rtl/dbf_port.sv
module dbf_port #(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] raw_i,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  limit_i,
  output logic [PORT_W-1:0] data_o
);
  logic [PORT_W-1:0] filt;

  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    dbf_bit_cell #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_i[b]),
      .tick_i (tick_i),
      .en_i   (en_i),
      .limit_i(limit_i),
      .filt_o (filt[b])
    );
  end

  assign data_o = en_i ? filt : raw_i;

endmodule

// File: rtl/debounce_filter.sv
module debounce_filter import dbf_pkg::*; #(
  parameter int unsigned NUM_PORTS   = 6,
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned GROUP_PORTS = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOG2_T0     = 5,
  parameter int unsigned LOG2_T1     = 9,
  parameter int unsigned LOG2_T2     = 13,
  parameter int unsigned LOG2_T3     = 16
) (
  input  logic                                               clk_i,
  input  logic                                               rst_ni,
  input  logic [NUM_PORTS*PORT_W-1:0]                        raw_i,
  input  logic                                               int_tick_i,
  input  logic                                               ext_clk_i,
  input  logic                                               clk_sel_i,
  input  logic [2*((NUM_PORTS+GROUP_PORTS-1)/GROUP_PORTS)-1:0] dur_code_i,
  input  logic [NUM_PORTS-1:0]                               filt_en_i,
  output logic [NUM_PORTS*PORT_W-1:0]                        data_o
);
  localparam int unsigned NUM_GROUPS = (NUM_PORTS + GROUP_PORTS - 1) / GROUP_PORTS;
  localparam int unsigned CNT_W      = dbf_max4(LOG2_T0, LOG2_T1, LOG2_T2, LOG2_T3);

  logic             deb_tick;
  logic [CNT_W-1:0] grp_lim [NUM_GROUPS];

  dbf_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_tick_i(int_tick_i),
    .ext_clk_i (ext_clk_i),
    .clk_sel_i (clk_sel_i),
    .tick_o    (deb_tick)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    dbf_dur_decode #(
      .LOG2_T0(LOG2_T0),
      .LOG2_T1(LOG2_T1),
      .LOG2_T2(LOG2_T2),
      .LOG2_T3(LOG2_T3),
      .CNT_W  (CNT_W)
    ) u_dec (
      .code_i (dur_code_i[2*g +: 2]),
      .limit_o(grp_lim[g])
    );
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned GRP = p / GROUP_PORTS;
    dbf_port #(
      .PORT_W     (PORT_W),
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_port (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw_i[p*PORT_W +: PORT_W]),
      .tick_i (deb_tick),
      .en_i   (filt_en_i[p]),
      .limit_i(grp_lim[GRP]),
      .data_o (data_o[p*PORT_W +: PORT_W])
    );
  end

endmodule

// File: rtl/dbf_checker.sv
module dbf_checker #(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned PORT_W    = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_PORTS*PORT_W-1:0] raw_i,
  input logic [NUM_PORTS-1:0]        filt_en_i,
  input logic                        deb_tick_i,
  input logic [NUM_PORTS*PORT_W-1:0] data_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !filt_en_i[p] |-> data_o[p*PORT_W +: PORT_W] == raw_i[p*PORT_W +: PORT_W]); // R6

    for (genvar b = 0; b < PORT_W; b++) begin : g_b
      localparam int unsigned IDX = p*PORT_W + b;

      AST_RESET_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_en_i[p] && !$past(rst_ni)) |-> !data_o[IDX]); // R1

      AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_en_i[p] && $past(filt_en_i[p]) && !$past(deb_tick_i)) |-> $stable(data_o[IDX])); // R5

      AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_en_i[p] && $past(filt_en_i[p]) && $past(filt_en_i[p], 2) &&
         ($past(data_o[IDX]) != $past(data_o[IDX], 2))) |-> $stable(data_o[IDX])); // R4
    end
  end
endmodule

bind debounce_filter dbf_checker #(
  .NUM_PORTS(NUM_PORTS),
  .PORT_W   (PORT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .raw_i     (raw_i),
  .filt_en_i (filt_en_i),
  .deb_tick_i(deb_tick),
  .data_o    (data_o)
);

// File: tb/sim_debounce_filter.sv
module sim_debounce_filter;
  localparam int NP = 4, PW = 8, GP = 2, NG = 2, DW = NP*PW;
  localparam int L0 = 2, L1 = 3, L2 = 4, L3 = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] raw;
  logic          int_tick, ext_clk, clk_sel;
  logic [2*NG-1:0] dur;
  logic [NP-1:0] en;
  logic [DW-1:0] dout;
  int  vectors = 0, fails = 0;
  bit  done = 1'b0, cmp_on = 1'b0;

  debounce_filter #(
    .NUM_PORTS(NP), .PORT_W(PW), .GROUP_PORTS(GP), .SYNC_STAGES(2),
    .LOG2_T0(L0), .LOG2_T1(L1), .LOG2_T2(L2), .LOG2_T3(L3)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .int_tick_i(int_tick),
    .ext_clk_i(ext_clk), .clk_sel_i(clk_sel), .dur_code_i(dur),
    .filt_en_i(en), .data_o(dout)
  );

  // R2: code c selects 2^Lc ticks
  function automatic int ticks_for(input logic [1:0] c);
    case (c)
      2'd0: return 1 << L0;
      2'd1: return 1 << L1;
      2'd2: return 1 << L2;
      default: return 1 << L3;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model built from the requirements
  logic m_s0 [DW], m_s1 [DW], m_prev [DW], m_out [DW];
  int   m_cnt [DW];
  logic [2:0] m_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < DW; b++) begin
        m_s0[b] <= 1'b0; m_s1[b] <= 1'b0; m_prev[b] <= 1'b0; m_out[b] <= 1'b0; m_cnt[b] <= 0;
      end
      m_e <= '0;
    end else begin
      logic tk;
      tk = clk_sel ? int_tick : (m_e[1] & ~m_e[2]);
      m_e <= {m_e[1:0], ext_clk};
      for (int b = 0; b < DW; b++) begin
        int n;
        logic s;
        n = ticks_for(dur[2*((b/PW)/GP) +: 2]);
        s = m_s1[b];
        m_s0[b] <= raw[b];
        m_s1[b] <= m_s0[b];
        m_prev[b] <= s;
        if (!en[b/PW]) begin
          m_out[b] <= s; m_cnt[b] <= 0;
        end else if (s != m_prev[b] || s == m_out[b]) begin
          m_cnt[b] <= 0;
        end else if (tk) begin
          if (m_cnt[b] >= n - 1) begin m_out[b] <= s; m_cnt[b] <= 0; end
          else m_cnt[b] <= m_cnt[b] + 1;
        end
      end
    end
  end

  // R8: full-word compare against the model every cycle
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on && !done) begin
      logic [DW-1:0] e;
      for (int b = 0; b < DW; b++) e[b] = en[b/PW] ? m_out[b] : raw[b];
      check(dout === e, "R8 model", dout, e);
    end
  end

  task automatic mid();
    @(posedge clk); #2;
  endtask

  task automatic step_latency(input int b, input int exp_n, input string tag);
    logic old;
    int got;
    got = -1;
    old = dout[b];
    raw[b] = ~raw[b];
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk); #1;
      if (dout[b] !== old) begin got = k; break; end
    end
    check(got == exp_n, tag, DW'(got), DW'(exp_n));
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0d5e_1a7b));
    rst_n = 1'b0; raw = '1; en = '1; clk_sel = 1'b1; int_tick = 1'b1; ext_clk = 1'b0; dur = '0;
    repeat (3) @(posedge clk);
    #1 check(dout == '0, "R1 reset", dout, '0);
    mid(); raw = '0; rst_n = 1'b1; cmp_on = 1'b1;
    repeat (10) mid();

    // R2 / R3: latency per code with a tick every cycle
    for (int c = 0; c < 4; c++) begin
      dur = {logic'(c[1]), logic'(c[0]), logic'(c[1]), logic'(c[0])};
      repeat (2) mid();
      step_latency(0, ticks_for(c[1:0]) + 3, c == 0 ? "R3 latency" : "R2 code");
      repeat (40) mid();
    end

    // R7: group 0 code 0, group 1 code 1
    dur = 4'b01_00;
    repeat (2) mid();
    step_latency(16, ticks_for(2'd1) + 3, "R7 group1");
    repeat (4) mid();
    step_latency(3, ticks_for(2'd0) + 3, "R7 group0");
    repeat (10) mid();

    // R4: short pulse discarded, then restart after a bounce
    dur = 4'b01_01;
    repeat (2) mid();
    begin
      logic old5;
      bit seen;
      old5 = dout[5]; seen = 1'b0;
      raw[5] = ~raw[5];
      repeat (4) mid();
      raw[5] = ~raw[5];
      for (int k = 0; k < 20; k++) begin mid(); if (dout[5] !== old5) seen = 1'b1; end
      check(!seen, "R4 pulse", DW'(seen), '0);
      raw[5] = ~raw[5];
      repeat (5) mid();
      raw[5] = ~raw[5];
      mid();
      step_latency(5, ticks_for(2'd1) + 3, "R4 restart");
    end
    repeat (12) mid();

    // R8: neighbouring bits on independent counters
    dur = 4'b00_00;
    repeat (2) mid();
    raw[8] = ~raw[8];
    repeat (2) mid();
    step_latency(9, ticks_for(2'd0) + 3, "R8 independent");
    check(dout[8] == raw[8], "R8 neighbour", DW'(dout[8]), DW'(raw[8]));
    repeat (10) mid();

    // R5: external source, no edges then edges; internal with no strobe
    clk_sel = 1'b0; ext_clk = 1'b0;
    repeat (4) mid();
    begin
      logic old1;
      old1 = dout[1];
      raw[1] = ~raw[1];
      repeat (30) mid();
      check(dout[1] == old1, "R5 no ext edge", DW'(dout[1]), DW'(old1));
      for (int k = 0; k < 40; k++) begin
        if (k % 2 == 0) ext_clk = ~ext_clk;
        mid();
      end
      check(dout[1] == raw[1], "R5 ext edges", DW'(dout[1]), DW'(raw[1]));
      clk_sel = 1'b1; int_tick = 1'b0;
      old1 = dout[1];
      raw[1] = ~raw[1];
      repeat (30) mid();
      check(dout[1] == old1, "R5 no strobe", DW'(dout[1]), DW'(old1));
      int_tick = 1'b1;
      repeat (10) mid();
      check(dout[1] == raw[1], "R5 strobe", DW'(dout[1]), DW'(raw[1]));
    end

    // R6: bypass is combinational
    en[1] = 1'b0;
    raw[15:8] = 8'hA5;
    #1 check(dout[15:8] == 8'hA5, "R6 bypass", DW'(dout[15:8]), DW'(8'hA5));
    mid();
    raw[15:8] = 8'h5A;
    #1 check(dout[15:8] == 8'h5A, "R6 bypass", DW'(dout[15:8]), DW'(8'h5A));

    // R9: enabling on a stable input gives no change
    repeat (5) mid();
    en[1] = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1 check(dout[15:8] == 8'h5A, "R9 enable", DW'(dout[15:8]), DW'(8'h5A));
      mid();
    end

    // random phase
    for (int cyc = 0; cyc < 20000; cyc++) begin
      mid();
      for (int b = 0; b < DW; b++) if ($urandom % 24 == 0) raw[b] = ~raw[b];
      if ($urandom % 3 == 0) ext_clk = ~ext_clk;
      int_tick = ($urandom % 2) == 0;
      if ($urandom % 400 == 0) dur = 4'($urandom);
      if ($urandom % 300 == 0) en = 4'($urandom);
      if ($urandom % 700 == 0) clk_sel = ~clk_sel;
    end

    repeat (4) mid();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule